// File: doc/BRIEF.md
# Four-Channel PWM Control Register Block

This block is the register front end of a small pulse-width modulation unit with four independent channels. A processor reaches it through a plain word-addressed register bus with an address, write data, a write strobe, a read strobe and registered read data. Global registers start and stop channels and report which channels are running and which have begun a new period. A bank of registers for each channel holds the channel's mode, its duty and period counts, and a staging word that is applied at the next period boundary.

Each channel runs a period counter that is clocked by a power-of-two prescaler. A period opens with the output at its inactive level and switches to the active level once the counter reaches the duty count. A stop request does not cut a period short: the channel finishes its current period first, so the running bit in the status word lags the command. Every period start sets a flag bit, and a read of the flag register returns all flags and clears them together.

Top module: `pwm_regctl`

## Requirements
- R1: After reset every register reads 0, no channel runs, and every `pwm_o` bit sits at 0.
- R2: Global words are at byte offset 0x04 (start), 0x08 (stop), 0x0C (running status) and 0x1C (period flags). Channel n's bank starts at 0x200 + n*0x20, with mode at +0x00, duty at +0x04, period at +0x08 and staging at +0x10. The mode word keeps only bits 3:0 (prescale select), bit 9 (polarity) and bit 10 (staging target); other bits read 0. Duty, period and staging keep and return their low PER_W bits.
- R3: Writing 1 to bit n of the start word starts a stopped channel n with its counters cleared. Zero bits, and 1 bits for channels already running, change nothing.
- R4: Writing 1 to bit n of the stop word ends channel n at the close of its current period; the channel keeps running until then. Zero bits change nothing.
- R5: Bits NUM_CH-1:0 of the status word show which channels are running; a bit drops in the same clock edge in which its channel stops.
- R6: A period-flag bit is set whenever its channel starts a period, either on a start command or when a period ends and the channel keeps running; a stop does not set it. A read of the flag word returns the flags and clears them, but a start in the same cycle as that read leaves its bit set.
- R7: A period lasts P counter steps for period count P (0 acts as 1), and the counter steps once every 2^k clock cycles, where k is the prescale select clamped to 10.
- R8: The output is inactive while the counter is below the duty count and active from there to the end of the period. Polarity bit 0 makes the active level 1; bit 1 inverts the output. A stopped channel drives its inactive level.
- R9: A staging write is applied at the channel's next period start: to the duty count when mode bit 10 is 0, to the period count when it is 1. Before that point the target keeps its old value.
- R10: Reads of unmapped offsets, including banks for channels beyond NUM_CH and the status and flag words when written, return 0, and writes there change no state.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and is 0 in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_re` |
| pwm_o | output | NUM_CH | Channel waveform outputs |

## Verification
Channels are run with different period counts, duty counts, polarities and prescale settings. Flag-register reads are placed on the exact edge of a period boundary and on the edge after it, which tells a flag that is kept apart from one that is lost, and tells a correct prescaled period length from an unscaled one. Stop commands are followed by status reads just before and just after the period end, which separates a deferred stop from an immediate one. Staging writes are read back before and after the boundary for both targets, and unmapped writes are read back through both the unmapped and the neighbouring mapped offsets.

// File: rtl/pwm_regctl_pkg.sv
package pwm_regctl_pkg;

    // Global word offsets (bytes)
    localparam int unsigned OFS_START = 'h04;
    localparam int unsigned OFS_STOP  = 'h08;
    localparam int unsigned OFS_STAT  = 'h0C;
    localparam int unsigned OFS_FLAG  = 'h1C;

    // Channel bank layout
    localparam int unsigned BANK_BASE     = 'h200;
    localparam int unsigned BANK_STRIDE_LG = 5;
    localparam int unsigned FLD_MODE  = 'h00;
    localparam int unsigned FLD_DUTY  = 'h04;
    localparam int unsigned FLD_PRD   = 'h08;
    localparam int unsigned FLD_STAGE = 'h10;

    // Mode word fields
    localparam int unsigned MODE_PRES_W     = 4;
    localparam int unsigned MODE_POL_BIT    = 9;
    localparam int unsigned MODE_TARGET_BIT = 10;

    // Prescaler limits
    localparam int unsigned PRES_MAX  = 10;
    localparam int unsigned PRE_CNT_W = PRES_MAX;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DUTY,
        SEL_PRD,
        SEL_STAGE
    } bank_fld_e;

    typedef struct packed {
        logic [MODE_PRES_W-1:0] pres;
        logic                   pol;
        logic                   tgt_prd;
    } mode_t;

endpackage

// File: rtl/pwm_regctl_decode.sv
module pwm_regctl_decode
    import pwm_regctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NUM_CH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              start_hit,
    output logic              stop_hit,
    output logic              stat_hit,
    output logic              flag_hit,
    output logic [NUM_CH-1:0] bank_sel,
    output bank_fld_e         fld
);

    localparam int unsigned TAG_W = ADDR_W - BANK_STRIDE_LG;

    always_comb begin
        start_hit = (addr == ADDR_W'(OFS_START));
        stop_hit  = (addr == ADDR_W'(OFS_STOP));
        stat_hit  = (addr == ADDR_W'(OFS_STAT));
        flag_hit  = (addr == ADDR_W'(OFS_FLAG));

        for (int i = 0; i < NUM_CH; i++) begin
            bank_sel[i] = (addr[ADDR_W-1:BANK_STRIDE_LG] ==
                           TAG_W'((BANK_BASE >> BANK_STRIDE_LG) + i));
        end

        case (addr[BANK_STRIDE_LG-1:0])
            BANK_STRIDE_LG'(FLD_MODE):  fld = SEL_MODE;
            BANK_STRIDE_LG'(FLD_DUTY):  fld = SEL_DUTY;
            BANK_STRIDE_LG'(FLD_PRD):   fld = SEL_PRD;
            BANK_STRIDE_LG'(FLD_STAGE): fld = SEL_STAGE;
            default:                    fld = SEL_NONE;
        endcase

        if (bank_sel == '0) begin
            fld = SEL_NONE;
        end
    end

endmodule

// File: rtl/pwm_regctl_chan.sv
module pwm_regctl_chan
    import pwm_regctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_duty,
    input  logic              wr_prd,
    input  logic              wr_stage,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    output logic              run_o,
    output logic              begin_o,
    output logic              close_o,
    output mode_t             mode_o,
    output logic [PER_W-1:0]  duty_o,
    output logic [PER_W-1:0]  prd_o,
    output logic [PER_W-1:0]  stage_o,
    output logic              wave_o
);

    localparam int unsigned MASK_W = PRE_CNT_W + 1;

    typedef struct packed {
        logic                 run;
        logic                 stop_pend;
        logic [PER_W-1:0]     cnt;
        logic [PRE_CNT_W-1:0] pre;
        mode_t                mode;
        logic [PER_W-1:0]     duty;
        logic [PER_W-1:0]     prd;
        logic [PER_W-1:0]     stage;
        logic                 stage_vld;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic [MODE_PRES_W-1:0] pres_eff;
    logic [PRE_CNT_W-1:0]   pre_mask;
    logic                   tick;
    logic [PER_W-1:0]       last_cnt;
    logic                   close_c;
    logic                   begin_c;
    logic                   wdata_unused;

    assign wdata_unused = ^wdata;

    always_comb begin
        pres_eff = (st_q.mode.pres > MODE_PRES_W'(PRES_MAX)) ?
                   MODE_PRES_W'(PRES_MAX) : st_q.mode.pres;
        pre_mask = PRE_CNT_W'((MASK_W'(1) << pres_eff) - MASK_W'(1));
        tick     = ((st_q.pre & pre_mask) == pre_mask);
        last_cnt = (st_q.prd == '0) ? '0 : st_q.prd - PER_W'(1);
        close_c  = st_q.run && tick && (st_q.cnt >= last_cnt);
        begin_c  = 1'b0;

        st_d = st_q;

        if (wr_mode) begin
            st_d.mode.pres    = wdata[MODE_PRES_W-1:0];
            st_d.mode.pol     = wdata[MODE_POL_BIT];
            st_d.mode.tgt_prd = wdata[MODE_TARGET_BIT];
        end
        if (wr_duty) begin
            st_d.duty = wdata[PER_W-1:0];
        end
        if (wr_prd) begin
            st_d.prd = wdata[PER_W-1:0];
        end
        if (wr_stage) begin
            st_d.stage     = wdata[PER_W-1:0];
            st_d.stage_vld = 1'b1;
        end

        if (st_q.run) begin
            st_d.pre = st_q.pre + PRE_CNT_W'(1);
            if (tick) begin
                st_d.cnt = st_q.cnt + PER_W'(1);
            end
            if (stop_cmd) begin
                st_d.stop_pend = 1'b1;
            end
            if (close_c) begin
                st_d.cnt = '0;
                st_d.pre = '0;
                if (st_q.stop_pend || stop_cmd) begin
                    st_d.run       = 1'b0;
                    st_d.stop_pend = 1'b0;
                end else begin
                    begin_c = 1'b1;
                end
            end
        end else if (start_cmd) begin
            st_d.run       = 1'b1;
            st_d.stop_pend = 1'b0;
            st_d.cnt       = '0;
            st_d.pre       = '0;
            begin_c        = 1'b1;
        end

        if (begin_c && st_q.stage_vld) begin
            if (st_q.mode.tgt_prd) begin
                st_d.prd = st_q.stage;
            end else begin
                st_d.duty = st_q.stage;
            end
            st_d.stage_vld = wr_stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign begin_o = begin_c;
    assign close_o = close_c;
    assign mode_o  = st_q.mode;
    assign duty_o  = st_q.duty;
    assign prd_o   = st_q.prd;
    assign stage_o = st_q.stage;
    assign wave_o  = (st_q.run && (st_q.cnt >= st_q.duty)) ^ st_q.mode.pol;

endmodule

// File: rtl/pwm_regctl_irq.sv
module pwm_regctl_irq #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] begin_vec,
    input  logic              rd_clr,
    output logic [NUM_CH-1:0] flag_o
);

    logic [NUM_CH-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (rd_clr ? '0 : flag_q) | begin_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/pwm_regctl.sv
module pwm_regctl
    import pwm_regctl_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    logic              start_hit, stop_hit, stat_hit, flag_hit;
    logic [NUM_CH-1:0] bank_sel;
    bank_fld_e         fld;

    logic [NUM_CH-1:0] start_cmd, stop_cmd;
    logic [NUM_CH-1:0] run_vec, begin_vec, close_vec, flag_vec, pol_vec;
    mode_t             mode_vec  [NUM_CH];
    logic [PER_W-1:0]  duty_vec  [NUM_CH];
    logic [PER_W-1:0]  prd_vec   [NUM_CH];
    logic [PER_W-1:0]  stage_vec [NUM_CH];

    logic [DATA_W-1:0] rdata_d, rdata_q;

    pwm_regctl_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) decode_i (
        .addr      (bus_addr),
        .start_hit (start_hit),
        .stop_hit  (stop_hit),
        .stat_hit  (stat_hit),
        .flag_hit  (flag_hit),
        .bank_sel  (bank_sel),
        .fld       (fld)
    );

    assign start_cmd = (bus_we && start_hit) ? bus_wdata[NUM_CH-1:0] : '0;
    assign stop_cmd  = (bus_we && stop_hit)  ? bus_wdata[NUM_CH-1:0] : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic bank_wr;
        assign bank_wr = bus_we && bank_sel[g];

        pwm_regctl_chan #(
            .DATA_W (DATA_W),
            .PER_W  (PER_W)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_mode   (bank_wr && (fld == SEL_MODE)),
            .wr_duty   (bank_wr && (fld == SEL_DUTY)),
            .wr_prd    (bank_wr && (fld == SEL_PRD)),
            .wr_stage  (bank_wr && (fld == SEL_STAGE)),
            .wdata     (bus_wdata),
            .start_cmd (start_cmd[g]),
            .stop_cmd  (stop_cmd[g]),
            .run_o     (run_vec[g]),
            .begin_o   (begin_vec[g]),
            .close_o   (close_vec[g]),
            .mode_o    (mode_vec[g]),
            .duty_o    (duty_vec[g]),
            .prd_o     (prd_vec[g]),
            .stage_o   (stage_vec[g]),
            .wave_o    (pwm_o[g])
        );

        assign pol_vec[g] = mode_vec[g].pol;
    end

    pwm_regctl_irq #(
        .NUM_CH (NUM_CH)
    ) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .begin_vec (begin_vec),
        .rd_clr    (bus_re && flag_hit),
        .flag_o    (flag_vec)
    );

    always_comb begin
        rdata_d = '0;
        if (bus_re) begin
            if (stat_hit) begin
                rdata_d[NUM_CH-1:0] = run_vec;
            end
            if (flag_hit) begin
                rdata_d[NUM_CH-1:0] = flag_vec;
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (bank_sel[i]) begin
                    case (fld)
                        SEL_MODE: begin
                            rdata_d[MODE_PRES_W-1:0]  = mode_vec[i].pres;
                            rdata_d[MODE_POL_BIT]     = mode_vec[i].pol;
                            rdata_d[MODE_TARGET_BIT]  = mode_vec[i].tgt_prd;
                        end
                        SEL_DUTY:  rdata_d = DATA_W'(duty_vec[i]);
                        SEL_PRD:   rdata_d = DATA_W'(prd_vec[i]);
                        SEL_STAGE: rdata_d = DATA_W'(stage_vec[i]);
                        default:   ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/pwm_regctl_chk.sv
module pwm_regctl_chk
    import pwm_regctl_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] pwm_o,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] begin_vec,
    input logic [NUM_CH-1:0] close_vec,
    input logic [NUM_CH-1:0] flag_vec,
    input logic [NUM_CH-1:0] pol_vec
);

    logic wdata_unused;
    assign wdata_unused = ^bus_wdata;

    // R11: no read strobe, no data
    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));

    // R6: a flag read with no period start leaves every flag clear
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(OFS_FLAG) && begin_vec == '0)
        |=> (flag_vec == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R3: start on a stopped channel makes it run
        a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(OFS_START) && bus_wdata[g] && !run_vec[g])
            |=> run_vec[g]);

        // R4: a running channel only stops at its period close
        a_r4_stop_at_close: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[g] && !close_vec[g]) |=> run_vec[g]);

        // R6: every period start leaves its flag set
        a_r6_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
            begin_vec[g] |=> flag_vec[g]);

        // R8: a stopped channel drives its inactive level
        a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[g] |-> (pwm_o[g] == pol_vec[g]));
    end

endmodule

bind pwm_regctl pwm_regctl_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pwm_o     (pwm_o),
    .run_vec   (run_vec),
    .begin_vec (begin_vec),
    .close_vec (close_vec),
    .flag_vec  (flag_vec),
    .pol_vec   (pol_vec)
);

// File: tb/pwm_regctl_tb_top.sv
module pwm_regctl_tb_top;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PER_W  = 16;

    localparam logic [ADDR_W-1:0] A_START = 12'h004;
    localparam logic [ADDR_W-1:0] A_STOP  = 12'h008;
    localparam logic [ADDR_W-1:0] A_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_FLAG  = 12'h01C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH-1:0] pwm_o;

    always #5 clk = ~clk;

    pwm_regctl #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PER_W  (PER_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [31:0] exp_q [$];
    logic [31:0] msk_q [$];
    string       tag_q [$];
    logic        arm = 1'b0;

    function automatic logic [ADDR_W-1:0] bank(int ch, int fld);
        return ADDR_W'(32'h200 + ch * 32'h20 + fld);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // driver: every operation takes exactly one cycle, starting at a negedge
    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] e, string req);
        exp_q.push_back(e); msk_q.push_back(32'hFFFF_FFFF); tag_q.push_back(req);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_any(logic [ADDR_W-1:0] a);
        exp_q.push_back('0); msk_q.push_back('0); tag_q.push_back("R6 flush");
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares read data one cycle after each strobe
    always @(posedge clk) arm <= bus_re;

    always @(negedge clk) begin
        if (arm) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read data", bus_rdata, 32'hDEAD_BEEF);
            end else begin
                logic [31:0] e, m;
                string t;
                e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
                check(t, bus_rdata & m, e & m);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R1 pwm idle after reset", 32'(pwm_o), 32'h0);
        rd(A_STAT, 32'h0, "R1 status after reset");
        rd(A_FLAG, 32'h0, "R1 flags after reset");
        rd(bank(0, 'h00), 32'h0, "R1 mode after reset");
        rd(bank(2, 'h08), 32'h0, "R1 period after reset");
        idle(1);
        check("R11 rdata zero without read", bus_rdata, 32'h0);

        // channel 0 setup and readback
        wr(bank(0, 'h00), 32'hFFFF_FFFF);
        rd(bank(0, 'h00), 32'h0000_060F, "R2 mode keeps only its fields");
        wr(bank(0, 'h00), 32'h0);
        wr(bank(0, 'h04), 32'd4);
        wr(bank(0, 'h08), 32'd10);
        rd(bank(0, 'h08), 32'd10, "R2 period readback");

        // start channel 0 at edge E
        wr(A_START, 32'h1);                          // E
        rd(A_STAT, 32'h1, "R5 running after start"); // E+1
        rd(A_FLAG, 32'h1, "R6 flag on start");       // E+2
        rd(A_FLAG, 32'h0, "R6 flag cleared by read"); // E+3
        check("R8 inactive before duty", 32'(pwm_o[0]), 32'h0);
        idle(2);                                     // E+5
        check("R8 active after duty", 32'(pwm_o[0]), 32'h1);
        idle(4);                                     // E+9
        rd(A_FLAG, 32'h0, "R6 read on boundary returns old"); // E+10
        rd(A_FLAG, 32'h1, "R6 boundary start kept, R7 ten steps"); // E+11
        wr(A_STOP, 32'h1);                           // E+12
        rd(A_STAT, 32'h1, "R4 still running after stop"); // E+13
        idle(6);                                     // E+19
        rd(A_STAT, 32'h1, "R5 status lags until close"); // E+20
        rd(A_STAT, 32'h0, "R4 stopped at close");    // E+21
        rd(A_FLAG, 32'h0, "R6 no flag on stop");     // E+22
        check("R8 stopped channel inactive", 32'(pwm_o[0]), 32'h0);

        // channel 1: inverted polarity, period 6, duty 2
        wr(bank(1, 'h00), 32'h0000_0200);
        wr(bank(1, 'h04), 32'd2);
        wr(bank(1, 'h08), 32'd6);
        check("R8 inverted idle level", 32'(pwm_o[1]), 32'h1);
        wr(A_START, 32'h2);                          // F
        wr(A_STOP, 32'h1);                           // F+1 zero bit for ch1
        rd(A_STAT, 32'h2, "R4 zero stop bit ignored"); // F+2
        check("R8 inverted active level", 32'(pwm_o[1]), 32'h0);
        wr(A_START, 32'h2);                          // F+3 already running
        rd(A_FLAG, 32'h2, "R6 ch1 start flag");      // F+4
        rd(A_FLAG, 32'h0, "R3 rerun start no flag"); // F+5
        rd(A_FLAG, 32'h0, "R3 boundary read old");   // F+6
        rd(A_FLAG, 32'h2, "R3 running start left counter"); // F+7
        wr(bank(1, 'h10), 32'd4);                    // F+8 stage duty
        rd(bank(1, 'h04), 32'd2, "R9 duty held before boundary"); // F+9
        idle(2);                                     // F+11
        rd(bank(1, 'h04), 32'd2, "R9 duty held up to boundary");  // F+12
        rd(bank(1, 'h04), 32'd4, "R9 duty staged at boundary");   // F+13
        wr(bank(1, 'h00), 32'h0000_0600);            // F+14 target period
        wr(bank(1, 'h10), 32'd8);                    // F+15
        rd(bank(1, 'h08), 32'd6, "R9 period held before boundary"); // F+16
        idle(1);                                     // F+17
        rd(bank(1, 'h08), 32'd6, "R9 period held up to boundary");  // F+18
        rd(bank(1, 'h08), 32'd8, "R9 period staged at boundary");   // F+19
        wr(A_STOP, 32'h2);                           // F+20
        wr(bank(2, 'h00), 32'h1);                    // F+21 prescale 1
        wr(bank(2, 'h08), 32'd3);                    // F+22
        idle(4);                                     // F+26 ch1 stops
        rd_any(A_FLAG);                              // F+27

        // channel 2: prescale 2, period 3 -> six clock cycles
        wr(A_START, 32'h4);                          // G
        rd(A_FLAG, 32'h4, "R6 ch2 start flag");      // G+1
        idle(4);                                     // G+5
        rd(A_FLAG, 32'h0, "R7 prescaled period not early"); // G+6
        rd(A_FLAG, 32'h4, "R7 prescaled period six cycles"); // G+7
        rd(A_STAT, 32'h4, "R5 only ch2 running");    // G+8

        // unmapped offsets
        wr(12'h100, 32'hFFFF);
        wr(bank(0, 'h14), 32'hFFFF);
        wr(bank(4, 'h00), 32'h5);
        wr(A_STAT, 32'hF);
        rd(12'h100, 32'h0, "R10 unmapped global reads zero");
        rd(bank(0, 'h14), 32'h0, "R10 bank gap reads zero");
        rd(bank(4, 'h00), 32'h0, "R10 bank past last channel");
        rd(12'h000, 32'h0, "R10 offset zero reads zero");
        rd(bank(0, 'h00), 32'h0, "R10 no alias into mode");
        rd(bank(0, 'h04), 32'd4, "R10 duty untouched");
        rd(A_STAT, 32'h4, "R10 status write ignored");

        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule